// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block is the control front end of a four-channel DMA unit. Software programs each channel through 16-bit writes: a source address, a destination address, a transfer count and a control word. The block decides when each channel has work to do. A channel can be started by its own control write, by a vertical- or horizontal-blank strobe from the display, or by a refill request from a sound FIFO. Which of these events starts a channel depends on the channel's timing field.

Requests are kept as one pending bit per channel. The block grants one channel at a time to an external transfer engine, always choosing the lowest-numbered pending channel. While a channel is granted, the block presents that channel's latched addresses, transfer count and control word. The engine answers with a one-cycle done pulse. The block then raises that channel's interrupt line if the channel asked for one, and disables the channel unless it is set to repeat.

Top module: `dma_trig_ctrl`

## Requirements
- R1: A write selects a register by byte offset: 0 source bits 15:0, 2 source bits 27:16 (only data bits 11:0 are kept), 4 destination bits 15:0, 6 destination bits 27:16 (data bits 11:0 kept), 8 transfer count, 10 control. Any other offset changes no register and raises `acc_err` for exactly the one cycle after the write.
- R2: A control write that sets the enable bit (bit 15) on a disabled channel with timing field (bits 13:12) equal to 0 makes that channel pending on the third clock edge after the write edge.
- R3: Every other control write clears that channel's pending bit. It also cancels a delayed start that has not yet fired, so that start never happens.
- R4: A `vbl_stb` pulse makes pending every enabled channel whose timing is 1. An `hbl_stb` pulse does the same for every enabled channel whose timing is 2.
- R5: A `fifo_req` pulse makes channel 1 or 2 pending only if that channel is enabled, has timing 3, and has a destination address equal to `fifo_addr`. Channels 0 and 3 never respond to it.
- R6: At most one `grant` bit is high at a time. When no channel is granted, the lowest-numbered pending channel is granted on the next edge and its pending bit is cleared. A new grant follows the done pulse one edge after the current grant drops.
- R7: `busy` is high exactly when at least one pending bit is set.
- R8: The edge that enables a channel latches its source, destination and count. A count of 0 is latched as 16384 for channels 0 to 2 and as 65536 for channel 3. While a channel is granted, `xfer_src`, `xfer_dst`, `xfer_cnt` and `xfer_ctl` show that channel's latched values and its control word.
- R9: A `done` pulse for the granted channel drops `grant` on the next edge. If control bit 14 of that channel is set, the same edge raises `irq_vec` bit n+8 for exactly one cycle.
- R10: On that done edge, a channel whose repeat bit (bit 9) is clear is disabled. A channel with repeat set stays enabled and responds to its trigger again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | 2 | Channel addressed by the write |
| wr_ofs | input | 4 | Byte offset of the register |
| wr_data | input | 16 | Write data |
| acc_err | output | 1 | One-cycle flag for a write to an invalid offset |
| vbl_stb | input | 1 | Vertical-blank trigger pulse |
| hbl_stb | input | 1 | Horizontal-blank trigger pulse |
| fifo_req | input | 1 | Sound FIFO refill request pulse |
| fifo_addr | input | 28 | Address of the FIFO making the request |
| done | input | 4 | Per-channel transfer-complete pulse from the engine |
| grant | output | 4 | One-hot start grant to the engine |
| xfer_src | output | 28 | Latched source address of the granted channel |
| xfer_dst | output | 28 | Latched destination address of the granted channel |
| xfer_cnt | output | 17 | Latched transfer count of the granted channel |
| xfer_ctl | output | 16 | Control word of the granted channel |
| busy | output | 1 | At least one channel is pending |
| irq_vec | output | 16 | Interrupt pulses, channel n on bit n+8 |

## Verification
A fault in the start delay is visible on `busy`: it rises one edge early or late relative to the control write, or it never rises after a cancelling write. A fault in the pending set shows up one edge after the grant. The wrong channel appears on `grant`, or `busy` stays high or low when it should not. A latching fault shows on the `xfer_*` outputs in the first cycle of the grant. A fault in the done handling shows on the next edge: an interrupt pulse missing or on the wrong bit, or a non-repeating channel that still answers its next trigger.

// File: rtl/dmat_pkg.sv
package dmat_pkg;

    typedef enum logic [1:0] {
        TIM_NOW  = 2'd0,
        TIM_VBL  = 2'd1,
        TIM_HBL  = 2'd2,
        TIM_FIFO = 2'd3
    } tim_e;

    // control word, MSB first; bit positions are decoded by the engine
    typedef struct packed {
        logic       en;      // 15
        logic       irq;     // 14
        tim_e       tim;     // 13:12
        logic       rsv_b;   // 11
        logic       wide;    // 10
        logic       rpt;     // 9
        logic [1:0] sstep;   // 8:7
        logic [1:0] dstep;   // 6:5
        logic [4:0] rsv_a;   // 4:0
    } ctl_t;

    localparam logic [3:0] OFS_SRC_LO = 4'd0;
    localparam logic [3:0] OFS_SRC_HI = 4'd2;
    localparam logic [3:0] OFS_DST_LO = 4'd4;
    localparam logic [3:0] OFS_DST_HI = 4'd6;
    localparam logic [3:0] OFS_COUNT  = 4'd8;
    localparam logic [3:0] OFS_CTL    = 4'd10;

endpackage

// File: rtl/dmat_regs.sv
module dmat_regs
    import dmat_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int AW   = 28,
    parameter int WC_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [$clog2(NCH)-1:0]        wr_ch,
    input  logic [3:0]                    wr_ofs,
    input  logic [15:0]                   wr_data,
    input  logic [NCH-1:0]                fin_i,
    output ctl_t [NCH-1:0]                ctl_o,
    output logic [NCH-1:0][AW-1:0]        dst_o,
    output logic [NCH-1:0][AW-1:0]        lsrc_o,
    output logic [NCH-1:0][AW-1:0]        ldst_o,
    output logic [NCH-1:0][WC_W:0]        lcnt_o,
    output logic [NCH-1:0]                start_o,
    output logic [NCH-1:0]                cancel_o,
    output logic                          err_o
);
    localparam int HI_W    = AW - 16;
    localparam int CW      = WC_W + 1;
    localparam int LONG_CH = NCH - 1;
    localparam logic [CW-1:0] MAX_LONG  = CW'(2 ** WC_W);
    localparam logic [CW-1:0] MAX_SHORT = CW'(2 ** (WC_W - 2));

    typedef struct packed {
        logic [AW-1:0]   src;
        logic [AW-1:0]   dst;
        logic [WC_W-1:0] wc;
        ctl_t            ctl;
        logic [AW-1:0]   lsrc;
        logic [AW-1:0]   ldst;
        logic [CW-1:0]   lcnt;
    } chan_s;

    typedef struct packed {
        chan_s [NCH-1:0] ch;
        logic            err;
    } st_s;

    st_s  st_d, st_q;
    ctl_t nctl;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        start_o  = '0;
        cancel_o = '0;
        nctl     = ctl_t'(wr_data);
        for (int i = 0; i < NCH; i++) begin
            if (fin_i[i] && !st_q.ch[i].ctl.rpt) st_d.ch[i].ctl.en = 1'b0;
        end
        if (wr_en) begin
            case (wr_ofs)
                OFS_SRC_LO: st_d.ch[wr_ch].src[15:0]   = wr_data;
                OFS_SRC_HI: st_d.ch[wr_ch].src[AW-1:16] = wr_data[HI_W-1:0];
                OFS_DST_LO: st_d.ch[wr_ch].dst[15:0]   = wr_data;
                OFS_DST_HI: st_d.ch[wr_ch].dst[AW-1:16] = wr_data[HI_W-1:0];
                OFS_COUNT:  st_d.ch[wr_ch].wc          = wr_data[WC_W-1:0];
                OFS_CTL: begin
                    if (nctl.en && !st_q.ch[wr_ch].ctl.en) begin
                        st_d.ch[wr_ch].lsrc = st_q.ch[wr_ch].src;
                        st_d.ch[wr_ch].ldst = st_q.ch[wr_ch].dst;
                        if (st_q.ch[wr_ch].wc != '0)
                            st_d.ch[wr_ch].lcnt = CW'(st_q.ch[wr_ch].wc);
                        else if (int'(wr_ch) == LONG_CH)
                            st_d.ch[wr_ch].lcnt = MAX_LONG;
                        else
                            st_d.ch[wr_ch].lcnt = MAX_SHORT;
                        if (nctl.tim == TIM_NOW) start_o[wr_ch]  = 1'b1;
                        else                     cancel_o[wr_ch] = 1'b1;
                    end else begin
                        cancel_o[wr_ch] = 1'b1;
                    end
                    st_d.ch[wr_ch].ctl = nctl;
                end
                default: st_d.err = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_out
        assign ctl_o[i]  = st_q.ch[i].ctl;
        assign dst_o[i]  = st_q.ch[i].dst;
        assign lsrc_o[i] = st_q.ch[i].lsrc;
        assign ldst_o[i] = st_q.ch[i].ldst;
        assign lcnt_o[i] = st_q.ch[i].lcnt;
    end
    assign err_o = st_q.err;

    // R1: a write to an unused offset leaves every channel register untouched
    a_r1_bad_ofs_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_ofs[0] || wr_ofs > OFS_CTL) && fin_i == '0) |=> $stable(st_q.ch));

    // R1: the error flag only follows an unused-offset write
    a_r1_err_source: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |-> $past(wr_en && (wr_ofs[0] || wr_ofs > OFS_CTL)));

endmodule

// File: rtl/dmat_delay.sv
module dmat_delay #(
    parameter int DLY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic cancel_i,
    output logic fire_o
);
    localparam int DW = $clog2(DLY + 1);

    logic [DW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cancel_i)          cnt_d = '0;
        else if (start_i)      cnt_d = DW'(DLY);
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign fire_o = (cnt_q == DW'(1)) && !cancel_i;

    // R3: a cancelled countdown never fires on the following cycle
    a_r3_no_fire_after_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cancel_i) |-> !fire_o);

endmodule

// File: rtl/dmat_arb.sv
module dmat_arb #(
    parameter int NCH      = 4,
    parameter int IRQ_W    = 16,
    parameter int IRQ_BASE = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCH-1:0]         set_i,
    input  logic [NCH-1:0]         clr_i,
    input  logic [NCH-1:0]         done_i,
    input  logic [NCH-1:0]         irq_en_i,
    output logic [NCH-1:0]         grant_o,
    output logic [$clog2(NCH)-1:0] sel_o,
    output logic [NCH-1:0]         fin_o,
    output logic                   busy_o,
    output logic [IRQ_W-1:0]       irq_o
);
    localparam int SW = $clog2(NCH);

    typedef struct packed {
        logic [NCH-1:0]   pend;
        logic [NCH-1:0]   grant;
        logic [SW-1:0]    sel;
        logic             active;
        logic [IRQ_W-1:0] irq;
    } st_s;

    st_s            st_d, st_q;
    logic [NCH-1:0] take;
    logic [SW-1:0]  pick;

    always_comb begin
        pick = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (st_q.pend[i]) pick = SW'(i);
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.irq = '0;
        fin_o    = '0;
        take     = '0;
        if (st_q.active) begin
            if (done_i[st_q.sel]) begin
                st_d.active     = 1'b0;
                st_d.grant      = '0;
                fin_o[st_q.sel] = 1'b1;
                if (irq_en_i[st_q.sel]) st_d.irq[IRQ_BASE + int'(st_q.sel)] = 1'b1;
            end
        end else if (st_q.pend != '0) begin
            st_d.active = 1'b1;
            st_d.sel    = pick;
            st_d.grant  = NCH'(1) << pick;
            take[pick]  = 1'b1;
        end
        st_d.pend = (st_q.pend & ~clr_i & ~take) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign grant_o = st_q.grant;
    assign sel_o   = st_q.sel;
    assign busy_o  = st_q.pend != '0;
    assign irq_o   = st_q.irq;

    // R6: never more than one channel granted
    a_r6_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.grant));

    // R6: a fresh grant goes to a channel that was pending
    a_r6_grant_was_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.grant != '0 && $past(st_q.grant) == '0) |-> (($past(st_q.pend) & st_q.grant) != '0));

    // R6: no lower-numbered channel was pending when a grant was issued
    a_r6_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.grant != '0 && $past(st_q.grant) == '0) |-> (($past(st_q.pend) & (st_q.grant - 1'b1)) == '0));

    // R9: an interrupt pulse follows a done pulse while a grant was held
    a_r9_irq_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.irq != '0) |-> ($past(st_q.active) && $past(done_i) != '0));

    // R9: interrupt pulses last a single cycle
    a_r9_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.irq != '0) |=> (st_q.irq == '0));

endmodule

// File: rtl/dma_trig_ctrl.sv
module dma_trig_ctrl
    import dmat_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int AW       = 28,
    parameter int WC_W     = 16,
    parameter int DLY      = 3,
    parameter int FIFO_LO  = 1,
    parameter int FIFO_HI  = 2,
    parameter int IRQ_W    = 16,
    parameter int IRQ_BASE = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [$clog2(NCH)-1:0] wr_ch,
    input  logic [3:0]             wr_ofs,
    input  logic [15:0]            wr_data,
    output logic                   acc_err,
    input  logic                   vbl_stb,
    input  logic                   hbl_stb,
    input  logic                   fifo_req,
    input  logic [AW-1:0]          fifo_addr,
    input  logic [NCH-1:0]         done,
    output logic [NCH-1:0]         grant,
    output logic [AW-1:0]          xfer_src,
    output logic [AW-1:0]          xfer_dst,
    output logic [WC_W:0]          xfer_cnt,
    output logic [15:0]            xfer_ctl,
    output logic                   busy,
    output logic [IRQ_W-1:0]       irq_vec
);
    localparam int SW = $clog2(NCH);

    ctl_t [NCH-1:0]         ctl;
    logic [NCH-1:0][AW-1:0] dst, lsrc, ldst;
    logic [NCH-1:0][WC_W:0] lcnt;
    logic [NCH-1:0]         start, cancel, fire, trig, fin, irq_en;
    logic [SW-1:0]          sel;

    dmat_regs #(.NCH(NCH), .AW(AW), .WC_W(WC_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_ch    (wr_ch),
        .wr_ofs   (wr_ofs),
        .wr_data  (wr_data),
        .fin_i    (fin),
        .ctl_o    (ctl),
        .dst_o    (dst),
        .lsrc_o   (lsrc),
        .ldst_o   (ldst),
        .lcnt_o   (lcnt),
        .start_o  (start),
        .cancel_o (cancel),
        .err_o    (acc_err)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        localparam bit FIFO_OK = (i >= FIFO_LO) && (i <= FIFO_HI);

        dmat_delay #(.DLY(DLY)) u_dly (
            .clk      (clk),
            .rst_n    (rst_n),
            .start_i  (start[i]),
            .cancel_i (cancel[i]),
            .fire_o   (fire[i])
        );

        assign trig[i] = ctl[i].en &&
                         ((ctl[i].tim == TIM_VBL && vbl_stb) ||
                          (ctl[i].tim == TIM_HBL && hbl_stb) ||
                          (FIFO_OK && ctl[i].tim == TIM_FIFO && fifo_req && dst[i] == fifo_addr));
        assign irq_en[i] = ctl[i].irq;

        // R5: channels outside the FIFO range never pend on a FIFO request alone
        if (!FIFO_OK) begin : g_nofifo
            a_r5_fifo_range: assert property (@(posedge clk) disable iff (!rst_n)
                (fifo_req && !vbl_stb && !hbl_stb && !fire[i]) |-> !trig[i]);
        end
    end

    dmat_arb #(.NCH(NCH), .IRQ_W(IRQ_W), .IRQ_BASE(IRQ_BASE)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (trig | fire),
        .clr_i    (cancel),
        .done_i   (done),
        .irq_en_i (irq_en),
        .grant_o  (grant),
        .sel_o    (sel),
        .fin_o    (fin),
        .busy_o   (busy),
        .irq_o    (irq_vec)
    );

    assign xfer_src = lsrc[sel];
    assign xfer_dst = ldst[sel];
    assign xfer_cnt = lcnt[sel];
    assign xfer_ctl = 16'(ctl[sel]);

endmodule

// File: tb/sim_dma_trig_ctrl.sv
`timescale 1ns/1ps
module sim_dma_trig_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_ch = '0;
    logic [3:0]  wr_ofs = '0;
    logic [15:0] wr_data = '0;
    logic        acc_err;
    logic        vbl_stb = 1'b0, hbl_stb = 1'b0, fifo_req = 1'b0;
    logic [27:0] fifo_addr = '0;
    logic [3:0]  done = '0;
    logic [3:0]  grant;
    logic [27:0] xfer_src, xfer_dst;
    logic [16:0] xfer_cnt;
    logic [15:0] xfer_ctl;
    logic        busy;
    logic [15:0] irq_vec;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    always #2.5 clk = ~clk;

    dma_trig_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_ofs(wr_ofs),
        .wr_data(wr_data), .acc_err(acc_err), .vbl_stb(vbl_stb), .hbl_stb(hbl_stb),
        .fifo_req(fifo_req), .fifo_addr(fifo_addr), .done(done), .grant(grant),
        .xfer_src(xfer_src), .xfer_dst(xfer_dst), .xfer_cnt(xfer_cnt),
        .xfer_ctl(xfer_ctl), .busy(busy), .irq_vec(irq_vec)
    );

    typedef struct packed {
        logic [1:0]  ch;
        logic [15:0] slo, shi, dlo, dhi, wc, ctl;
        logic [27:0] esrc, edst;
        logic [16:0] ecnt;
    } vec_t;

    localparam vec_t TBL [4] = '{
        '{2'd0, 16'h1234, 16'hFFFF, 16'h0002, 16'h0300, 16'h0000, 16'hC000, 28'hFFF1234, 28'h3000002, 17'h04000},
        '{2'd1, 16'h0010, 16'h0002, 16'h0020, 16'h0003, 16'h0005, 16'h8400, 28'h0020010, 28'h0030020, 17'h00005},
        '{2'd2, 16'hABCD, 16'h0801, 16'h1111, 16'hF222, 16'hFFFF, 16'hC0C0, 28'h801ABCD, 28'h2221111, 17'h0FFFF},
        '{2'd3, 16'h0000, 16'h0000, 16'h0004, 16'h0000, 16'h0000, 16'hC000, 28'h0000000, 28'h0000004, 17'h10000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] ch, input logic [3:0] ofs, input logic [15:0] data);
        wr_en = 1'b1; wr_ch = ch; wr_ofs = ofs; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_done(input logic [3:0] m);
        done = m;
        @(negedge clk);
        done = '0;
    endtask

    task automatic fifo_pulse(input logic [27:0] a);
        fifo_req = 1'b1; fifo_addr = a;
        @(negedge clk);
        fifo_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("reset busy R7", busy, 0);
        chk("reset grant R6", grant, 0);
        chk("reset irq R9", irq_vec, 0);
        chk("reset err R1", acc_err, 0);

        // table: program, start immediately, check timing, latched values, irq
        for (int k = 0; k < 4; k++) begin
            wr(TBL[k].ch, 4'd0, TBL[k].slo);
            wr(TBL[k].ch, 4'd2, TBL[k].shi);
            wr(TBL[k].ch, 4'd4, TBL[k].dlo);
            wr(TBL[k].ch, 4'd6, TBL[k].dhi);
            wr(TBL[k].ch, 4'd8, TBL[k].wc);
            wr(TBL[k].ch, 4'd10, TBL[k].ctl);
            @(negedge clk);
            @(negedge clk);
            chk("R2 not pending before third edge", busy, 0);
            @(negedge clk);
            chk("R2 pending at third edge (R7 busy)", busy, 1);
            chk("R6 no grant while pend registers", grant, 0);
            @(negedge clk);
            chk("R6 grant to channel", grant, 32'(4'b1 << TBL[k].ch));
            chk("R7 busy drops once granted", busy, 0);
            chk("R1 R8 source", xfer_src, TBL[k].esrc);
            chk("R1 R8 destination", xfer_dst, TBL[k].edst);
            chk("R8 count", xfer_cnt, TBL[k].ecnt);
            chk("R8 control", xfer_ctl, TBL[k].ctl);
            pulse_done(4'b1 << TBL[k].ch);
            chk("R9 grant drops on done", grant, 0);
            chk("R9 irq line", irq_vec, TBL[k].ctl[14] ? 32'(16'h1 << (TBL[k].ch + 8)) : 0);
            @(negedge clk);
            chk("R9 irq one cycle", irq_vec, 0);
        end

        // R1: invalid offsets flag an error and do not disturb channel 0
        wr(2'd0, 4'd12, 16'h0000);
        chk("R1 err after offset 12", acc_err, 1);
        @(negedge clk);
        chk("R1 err one cycle", acc_err, 0);
        wr(2'd0, 4'd1, 16'h0000);
        chk("R1 err after offset 1", acc_err, 1);
        wr(2'd0, 4'd3, 16'h0000);
        wr(2'd0, 4'd14, 16'h0000);
        wr(2'd0, 4'd10, 16'h8000);
        repeat (4) @(negedge clk);
        chk("R1 grant after bad writes", grant, 1);
        chk("R1 source untouched", xfer_src, 28'hFFF1234);
        chk("R1 destination untouched", xfer_dst, 28'h3000002);
        pulse_done(4'b0001);

        // R3: disable within the delay cancels the start
        wr(2'd0, 4'd10, 16'h8000);
        wr(2'd0, 4'd10, 16'h0000);
        begin
            logic seen = 1'b0;
            for (int c = 0; c < 6; c++) begin
                @(negedge clk);
                seen = seen | busy | (grant != 0);
            end
            chk("R3 cancelled start never pends", 32'(seen), 0);
        end
        // R3: rewriting an already enabled channel also cancels
        wr(2'd0, 4'd10, 16'h8000);
        wr(2'd0, 4'd10, 16'h8000);
        begin
            logic seen = 1'b0;
            for (int c = 0; c < 6; c++) begin
                @(negedge clk);
                seen = seen | busy | (grant != 0);
            end
            chk("R3 re-enable write cancels", 32'(seen), 0);
        end

        // R4 R10: blank triggers
        wr(2'd0, 4'd10, 16'h9200); // enabled already: cancel only, now timing 1 repeat
        wr(2'd2, 4'd10, 16'hD000); // timing 1, irq, no repeat
        wr(2'd1, 4'd10, 16'hA200); // timing 2, repeat
        @(negedge clk);
        chk("R3 non-immediate enable not pending", busy, 0);
        vbl_stb = 1'b1; @(negedge clk); vbl_stb = 1'b0;
        chk("R4 vblank pends (R7)", busy, 1);
        @(negedge clk);
        chk("R4 R6 vblank grants channel 0 first", grant, 4'b0001);
        chk("R6 channel 2 still pending", busy, 1);
        pulse_done(4'b0001);
        chk("R9 no irq without enable bit", irq_vec, 0);
        chk("R6 grant low between channels", grant, 0);
        @(negedge clk);
        chk("R6 then channel 2", grant, 4'b0100);
        chk("R7 idle after last grant", busy, 0);
        pulse_done(4'b0100);
        chk("R9 irq line 10", irq_vec, 16'h0400);
        @(negedge clk);
        hbl_stb = 1'b1; @(negedge clk); hbl_stb = 1'b0;
        @(negedge clk);
        chk("R4 hblank grants channel 1", grant, 4'b0010);
        pulse_done(4'b0010);
        vbl_stb = 1'b1; hbl_stb = 1'b1; @(negedge clk); vbl_stb = 1'b0; hbl_stb = 1'b0;
        @(negedge clk);
        chk("R10 repeat channel 0 retriggers", grant, 4'b0001);
        chk("R6 channel 1 waits", busy, 1);
        pulse_done(4'b0001);
        @(negedge clk);
        chk("R10 R6 channel 1 next", grant, 4'b0010);
        chk("R10 channel 2 disabled after done", busy, 0);
        pulse_done(4'b0010);

        // R5: FIFO requests
        wr(2'd1, 4'd4, 16'h00A0); wr(2'd1, 4'd6, 16'h0400); wr(2'd1, 4'd10, 16'hB200);
        wr(2'd2, 4'd4, 16'h00A4); wr(2'd2, 4'd6, 16'h0400); wr(2'd2, 4'd10, 16'hB200);
        wr(2'd3, 4'd4, 16'h00A0); wr(2'd3, 4'd6, 16'h0400); wr(2'd3, 4'd10, 16'hB200);
        @(negedge clk);
        fifo_pulse(28'h40000A0);
        chk("R5 fifo match pends", busy, 1);
        @(negedge clk);
        chk("R5 fifo grants channel 1", grant, 4'b0010);
        chk("R5 channel 3 ignores fifo", busy, 0);
        pulse_done(4'b0010);
        fifo_pulse(28'h40000A4);
        @(negedge clk);
        chk("R5 fifo grants channel 2", grant, 4'b0100);
        pulse_done(4'b0100);
        fifo_pulse(28'h40000A8);
        chk("R5 address mismatch ignored", busy, 0);
        @(negedge clk);
        chk("R5 no grant on mismatch", grant, 0);

        ended = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule